// File: doc/BRIEF.md
# Fixed Off-Time H-Bridge Current Chopper

This block regulates the current in one winding by chopping the four switches of an H-bridge. Each cycle of the chopper starts with an on-period. In that period the diagonal switch pair for the commanded polarity conducts. A digital comparator input reports that the sensed current has reached its setpoint. When it does, the on-period ends and an off-time of fixed length begins. The comparator is masked for a blanking window at the start of every on-period. Once the off-time expires, the next on-period starts without any outside action.

During the off-time the winding decays in one of two ways. In slow decay the current recirculates through both low-side switches. In mixed decay the opposite diagonal conducts first, for a fixed 5/16 of the off-time, which gives fast decay. Slow recirculation follows for the rest of the off-time. Within each leg, a dead-time gap is inserted before a switch turns on after its complement has turned off. A disable input forces all switches off while the sequencing keeps running. Every time is counted in system clock cycles.

Top module: `chopper_mixed_decay`

## Requirements
- R1: While rst_ni is low, all four switch outputs are 0. After release, the first on-period begins one clock later.
- R2: The switch vector {hs_a_o, ls_a_o, hs_b_o, ls_b_o} during an on-period is 1001 for polarity 1 and 0110 for polarity 0.
- R3: During the first BLANK_CYC cycles of an on-period, trip_i is ignored and the on-period continues.
- R4: A trip sampled after blanking ends the on-period. The conducting high-side switch is off one clock after that edge.
- R5: During slow decay, both high-side switches are off and both low-side switches are on (vector 0101).
- R6: In mixed decay, the off-time begins with exactly OFF_CYC*5/16 cycles in which the opposite diagonal is requested. The rest of the off-time is slow decay.
- R7: The off-time lasts exactly OFF_CYC cycles. After it, a new on-period starts by itself and begins with a blanking window.
- R8: The two switches of a leg are never on together. A switch turns on only after both switches of its leg have been off for at least DEAD_CYC cycles.
- R9: With disable_i high, all four outputs are 0 from the next clock on, and the sequencing continues. After release, the outputs follow the current phase, subject to the dead time.
- R10: dir_i and mixed_i are sampled only at the start of an on-period. A change made later takes effect at the next on-period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trip_i | input | 1 | Comparator: sensed current reached setpoint |
| dir_i | input | 1 | Commanded polarity (1: current from leg A to leg B) |
| mixed_i | input | 1 | Decay select (1: mixed, 0: slow) |
| disable_i | input | 1 | Forces all switches off when high |
| hs_a_o | output | 1 | High-side switch, leg A |
| ls_a_o | output | 1 | Low-side switch, leg A |
| hs_b_o | output | 1 | High-side switch, leg B |
| ls_b_o | output | 1 | Low-side switch, leg B |

## Verification
The bound checker watches several properties on every cycle. It checks that no leg is ever shot through and that each leg keeps its dead-time gap before any turn-on. It checks that disable clears the outputs and that a trip inside the blanking window never ends an on-period. It also checks that every off-time lasts exactly the configured number of cycles. Other behaviours can only be shown by the bench scenarios, which sample the switch vector in chosen cycles. These cover the diagonal chosen for each polarity, the length of the fast-decay part in mixed decay, the sampling of polarity and decay mode only at the start of an on-period, and the recovery into the ongoing phase after disable is released.

// File: rtl/chop_pkg.sv
`timescale 1ns/1ps
package chop_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_ON   = 2'd1,
    CH_FAST = 2'd2,
    CH_SLOW = 2'd3
  } chop_st_e;

  typedef struct packed {
    logic hs;
    logic ls;
  } leg_req_t;
endpackage

// File: rtl/chop_seq.sv
`timescale 1ns/1ps
module chop_seq
  import chop_pkg::*;
#(
  parameter int OFF_CYC   = 6000,
  parameter int BLANK_CYC = 200,
  parameter int FAST_CYC  = 1875,
  parameter int CW        = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trip_i,
  input  logic          dir_i,
  input  logic          mixed_i,
  output chop_st_e      st_o,
  output logic          pol_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYC);
  localparam logic [CW-1:0] FAST_END  = CW'(FAST_CYC - 1);
  localparam logic [CW-1:0] OFF_END   = CW'(OFF_CYC - 1);

  chop_st_e      st_q;
  logic [CW-1:0] cnt_q;
  logic          pol_q;
  logic          mix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CH_IDLE;
      cnt_q <= '0;
      pol_q <= 1'b0;
      mix_q <= 1'b0;
    end else begin
      unique case (st_q)
        CH_IDLE: begin
          st_q  <= CH_ON;
          cnt_q <= '0;
          pol_q <= dir_i;
          mix_q <= mixed_i;
        end
        CH_ON: begin
          if (cnt_q != BLANK_END) begin
            cnt_q <= cnt_q + 1'b1;
          end else if (trip_i) begin
            st_q  <= mix_q ? CH_FAST : CH_SLOW;
            cnt_q <= '0;
          end
        end
        CH_FAST: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == FAST_END) st_q <= CH_SLOW;
        end
        CH_SLOW: begin
          if (cnt_q == OFF_END) begin
            st_q  <= CH_ON;
            cnt_q <= '0;
            pol_q <= dir_i;
            mix_q <= mixed_i;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= CH_IDLE;
      endcase
    end
  end

  assign st_o  = st_q;
  assign pol_o = pol_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/chop_steer.sv
`timescale 1ns/1ps
module chop_steer
  import chop_pkg::*;
(
  input  chop_st_e       st_i,
  input  logic           pol_i,
  input  logic           dis_i,
  output leg_req_t [1:0] req_o
);
  // index 0 = leg A, index 1 = leg B
  always_comb begin
    req_o = '0;
    if (!dis_i) begin
      unique case (st_i)
        CH_ON: begin
          req_o[0] = pol_i ? 2'b10 : 2'b01;
          req_o[1] = pol_i ? 2'b01 : 2'b10;
        end
        CH_FAST: begin
          req_o[0] = pol_i ? 2'b01 : 2'b10;
          req_o[1] = pol_i ? 2'b10 : 2'b01;
        end
        CH_SLOW: begin
          req_o[0] = 2'b01;
          req_o[1] = 2'b01;
        end
        default: req_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/chop_leg.sv
`timescale 1ns/1ps
module chop_leg
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 95
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  leg_req_t req_i,
  output logic     hs_o,
  output logic     ls_o
);
  localparam int             DW       = $clog2(DEAD_CYC + 2);
  localparam logic [DW-1:0]  DEAD_END = DW'(DEAD_CYC);

  logic [DW-1:0] gap_q;
  logic          gap_ok;

  assign gap_ok = (gap_q == DEAD_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      hs_o  <= 1'b0;
      ls_o  <= 1'b0;
    end else begin
      if (hs_o || ls_o) gap_q <= '0;
      else if (!gap_ok) gap_q <= gap_q + 1'b1;
      // turn-off is immediate, turn-on waits for a full gap
      hs_o <= req_i.hs && (hs_o || (!ls_o && gap_ok));
      ls_o <= req_i.ls && (ls_o || (!hs_o && gap_ok));
    end
  end
endmodule

// File: rtl/chopper_mixed_decay.sv
`timescale 1ns/1ps
module chopper_mixed_decay
  import chop_pkg::*;
#(
  parameter int OFF_CYC   = 6000,
  parameter int BLANK_CYC = 200,
  parameter int DEAD_CYC  = 95
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_i,
  input  logic dir_i,
  input  logic mixed_i,
  input  logic disable_i,
  output logic hs_a_o,
  output logic ls_a_o,
  output logic hs_b_o,
  output logic ls_b_o
);
  localparam int FAST_CYC = OFF_CYC * 5 / 16;
  localparam int CMAX     = (OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC;
  localparam int CW       = $clog2(CMAX + 1);

  chop_st_e       st_w;
  logic           pol_w;
  logic [CW-1:0]  cnt_w;
  leg_req_t [1:0] req_w;
  logic [1:0]     hs_w;
  logic [1:0]     ls_w;

  chop_seq #(
    .OFF_CYC  (OFF_CYC),
    .BLANK_CYC(BLANK_CYC),
    .FAST_CYC (FAST_CYC),
    .CW       (CW)
  ) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trip_i (trip_i),
    .dir_i  (dir_i),
    .mixed_i(mixed_i),
    .st_o   (st_w),
    .pol_o  (pol_w),
    .cnt_o  (cnt_w)
  );

  chop_steer u_steer (
    .st_i (st_w),
    .pol_i(pol_w),
    .dis_i(disable_i),
    .req_o(req_w)
  );

  for (genvar g = 0; g < 2; g++) begin : g_leg
    chop_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req_i (req_w[g]),
      .hs_o  (hs_w[g]),
      .ls_o  (ls_w[g])
    );
  end

  assign hs_a_o = hs_w[0];
  assign ls_a_o = ls_w[0];
  assign hs_b_o = hs_w[1];
  assign ls_b_o = ls_w[1];
endmodule

// File: rtl/chop_chk.sv
`timescale 1ns/1ps
module chop_chk
  import chop_pkg::*;
#(
  parameter int OFF_CYC   = 6000,
  parameter int BLANK_CYC = 200,
  parameter int DEAD_CYC  = 95,
  parameter int CW        = 13
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          disable_i,
  input logic          hs_a_i,
  input logic          ls_a_i,
  input logic          hs_b_i,
  input logic          ls_b_i,
  input chop_st_e      st_i,
  input logic [CW-1:0] cnt_i
);
  localparam int GW = $clog2(DEAD_CYC + 3);
  localparam int RW = $clog2(OFF_CYC + 2);
  localparam logic [GW-1:0] GAP_SAT = GW'(DEAD_CYC + 1);

  logic [GW-1:0] gap_a_q, gap_b_q;
  logic [RW-1:0] off_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_a_q   <= '0;
      gap_b_q   <= '0;
      off_run_q <= '0;
    end else begin
      if (hs_a_i || ls_a_i) gap_a_q <= '0;
      else if (gap_a_q != GAP_SAT) gap_a_q <= gap_a_q + 1'b1;
      if (hs_b_i || ls_b_i) gap_b_q <= '0;
      else if (gap_b_q != GAP_SAT) gap_b_q <= gap_b_q + 1'b1;
      if (st_i == CH_FAST || st_i == CH_SLOW) off_run_q <= off_run_q + 1'b1;
      else off_run_q <= '0;
    end
  end

  a_r8_no_shoot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_a_i && ls_a_i) && !(hs_b_i && ls_b_i));

  a_r8_dead_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs_a_i) || $rose(ls_a_i)) |-> (int'(gap_a_q) >= DEAD_CYC));

  a_r8_dead_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hs_b_i) || $rose(ls_b_i)) |-> (int'(gap_b_q) >= DEAD_CYC));

  a_r9_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disable_i |=> !(hs_a_i || ls_a_i || hs_b_i || ls_b_i));

  a_r3_blank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == CH_ON && int'(cnt_i) < BLANK_CYC) |=> (st_i == CH_ON));

  a_r7_off_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == CH_ON && $past(st_i) != CH_ON && $past(st_i) != CH_IDLE)
      |-> (int'(off_run_q) == OFF_CYC));
endmodule

bind chopper_mixed_decay chop_chk #(
  .OFF_CYC  (OFF_CYC),
  .BLANK_CYC(BLANK_CYC),
  .DEAD_CYC (DEAD_CYC),
  .CW       (CW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .disable_i(disable_i),
  .hs_a_i   (hs_a_o),
  .ls_a_i   (ls_a_o),
  .hs_b_i   (hs_b_o),
  .ls_b_i   (ls_b_o),
  .st_i     (st_w),
  .cnt_i    (cnt_w)
);

// File: tb/sim_chopper_mixed_decay.sv
`timescale 1ns/1ps
module sim_chopper_mixed_decay;
  // OFF=32 -> fast part 10, blank 4, dead 2
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trip = 1'b0, dir = 1'b1, mixed = 1'b0, dis = 1'b0;
  logic hs_a, ls_a, hs_b, ls_b;
  int   cyc = 0;
  int   total = 0;
  int   bad = 0;

  typedef struct {
    int         at;
    logic [3:0] vec;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  chopper_mixed_decay #(.OFF_CYC(32), .BLANK_CYC(4), .DEAD_CYC(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .trip_i(trip), .dir_i(dir),
    .mixed_i(mixed), .disable_i(dis),
    .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b)
  );

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic push(input int at, input logic [3:0] v, input string tag);
    exp_t e;
    e.at = at; e.vec = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  // monitor: vector is {hs_a, ls_a, hs_b, ls_b}
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (e.at != cyc || {hs_a, ls_a, hs_b, ls_b} !== e.vec) begin
          bad++;
          $display("FAIL %s cycle %0d: actual %b expected %b", e.tag, cyc,
                   {hs_a, ls_a, hs_b, ls_b}, e.vec);
        end
      end
    end
  end

  initial begin
    #(5.0 * 3000);
    bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // expectations in ascending cycle order
    push(2,   4'b0000, "R1");
    push(3,   4'b1001, "R2");
    push(6,   4'b1001, "R3");   // trip held through blanking
    push(7,   4'b0001, "R4");
    push(8,   4'b0001, "R8");
    push(9,   4'b0001, "R8");
    push(10,  4'b0101, "R5");
    push(38,  4'b0101, "R7");
    push(39,  4'b0001, "R7");
    push(42,  4'b1001, "R7");
    push(50,  4'b1001, "R10");  // dir changed mid on-period
    push(52,  4'b0001, "R4");
    push(55,  4'b0101, "R5");
    push(83,  4'b0101, "R10");
    push(84,  4'b0100, "R10");
    push(87,  4'b0110, "R2");
    push(92,  4'b0100, "R10");  // mixed set mid period: still slow
    push(95,  4'b0101, "R10");
    push(124, 4'b0100, "R7");
    push(127, 4'b0110, "R2");
    push(132, 4'b0000, "R6");
    push(135, 4'b1001, "R6");
    push(141, 4'b1001, "R6");
    push(142, 4'b0001, "R6");
    push(145, 4'b0101, "R6");
    push(164, 4'b0100, "R7");
    push(167, 4'b0110, "R7");
    push(171, 4'b0000, "R9");
    push(175, 4'b0000, "R9");
    push(190, 4'b0000, "R9");
    push(191, 4'b0101, "R9");
    push(206, 4'b0100, "R9");
    push(209, 4'b0110, "R9");

    repeat (3) @(negedge clk);
    total++;
    if ({hs_a, ls_a, hs_b, ls_b} !== 4'b0000) begin
      bad++;
      $display("FAIL R1 in reset: actual %b expected 0000", {hs_a, ls_a, hs_b, ls_b});
    end
    rst_n = 1'b1;
    trip  = 1'b1;
    wait_cyc(7);   trip  = 1'b0;
    wait_cyc(45);  dir   = 1'b0;
    wait_cyc(50);  trip  = 1'b1;
    wait_cyc(51);  trip  = 1'b0;
    wait_cyc(88);  mixed = 1'b1;
    wait_cyc(90);  trip  = 1'b1;
    wait_cyc(91);  trip  = 1'b0;
    wait_cyc(130); trip  = 1'b1;
    wait_cyc(131); trip  = 1'b0;
    wait_cyc(170); dis   = 1'b1;
    wait_cyc(172); trip  = 1'b1;
    wait_cyc(173); trip  = 1'b0;
    wait_cyc(190); dis   = 1'b0;
    wait_cyc(215);
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      bad++;
      $display("FAIL %s cycle %0d: actual unchecked expected %b", e.tag, e.at, e.vec);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule